// File: doc/BRIEF.md
# March LR Memory Self-Test Controller

This controller tests a single-port synchronous RAM by running the March LR sequence over every address. It issues one RAM operation per clock: address, write data, write enable and read enable. Each read is compared with the value the algorithm expects. When a test finishes, it reports whether the memory passed. If it failed, it reports the first failing address and the index of the element that was running when that read was issued.

A word-oriented mode appends three elements that use the mixed backgrounds 01 and 10. These catch faults between neighbouring bits of one word that all-zero and all-one data cannot expose. Each 2-bit background is repeated across the data word. Bit 0 of the background fills the even bit positions and bit 1 fills the odd ones, so background 01 becomes ...0101 and background 10 becomes ...1010.

A pulse on `start` launches a test. `done` pulses once at the end. An input chooses whether the first mismatch stops the test or lets it run to completion.

Top module: `march_lr_bist`

## Requirements
- R1: After reset, `done`, `fail`, `mem_we` and `mem_re` are low.
- R2: In bit mode, six elements run, numbered 0 to 5:
  - E0: write 0, upward.
  - E1: read 0 then write 1, downward.
  - E2: read 1, write 0, read 0, read 0, write 1, upward.
  - E3: read 1 then write 0, upward.
  - E4: read 0, write 1, read 1, read 1, write 0, upward.
  - E5: read 0, upward.
  - Each address therefore sees 7 writes and 9 reads, one operation per clock.
  - Data is all-zero or all-one, and the memory ends all-zero.
- R3: Element 1 walks addresses downward. Its first read is at the top address, and its next read is one address below that.
- R4: With `word_mode` high at start, three upward elements follow:
  - E6: read 00, write 01, write 10, read 10.
  - E7: read 10, write 01, read 01.
  - E8: read 01.
  - Each address sees 10 writes and 14 reads.
  - Across the run, 2·N writes carry background 01 and N writes carry background 10. The memory ends holding the 01 background.
- R5: `done` is high for exactly one cycle. For a full run it rises after the (16·N+1)-th rising edge following the edge that samples `start` (24·N+1 in word mode), where N is 2^ADDR_W.
- R6: The first mismatching read sets `fail` and latches `fail_addr` and `fail_elem`, the 0-based element index. Later mismatches do not change them.
- R7: With `stop_on_fail` high, the test ends at the first mismatch. `fail` and `done` rise in the same cycle, earlier than a full run.
- R8: With `stop_on_fail` low, a failing test runs the full length and still reports the first failure.
- R9: `start` is ignored while a test is running: a pulse mid-run does not change the run length.
- R10: A fault-free memory completes with `fail` low.
- R11: A fault between bits 0 and 1 of a word (wired-AND) passes bit mode. In word mode it fails at address 0, element 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a test when idle |
| word_mode | input | 1 | Append the mixed-background elements (sampled at start) |
| stop_on_fail | input | 1 | End the test at the first mismatch |
| done | output | 1 | One-cycle end-of-test pulse |
| fail | output | 1 | A mismatch was seen in the current/last test |
| fail_addr | output | ADDR_W | Address of the first mismatch |
| fail_elem | output | 4 | Element index of the first mismatch |
| mem_addr | output | ADDR_W | RAM address |
| mem_wdata | output | DATA_W | RAM write data |
| mem_we | output | 1 | RAM write enable |
| mem_re | output | 1 | RAM read enable |
| mem_rdata | input | DATA_W | RAM read data, valid the cycle after a read |

## Verification
RAM operations appear on the port in the cycle after the edge that sampled `start`, one per clock. A read's data is compared one cycle later, so a failure is recorded one edge after the RAM returns the data. The end-of-test pulse follows the last operation by two edges. The bench counts rising edges from the start edge and compares that count with 16·N+1 or 24·N+1. It samples every port on the falling edge, so each count and each latched failure is read one half-period after the edge that produced it.

// File: rtl/march_lr_bist.sv
module march_lr_bist #(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              word_mode,
  input  logic              stop_on_fail,
  output logic              done,
  output logic              fail,
  output logic [ADDR_W-1:0] fail_addr,
  output logic [3:0]        fail_elem,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_we,
  output logic              mem_re,
  input  logic [DATA_W-1:0] mem_rdata
);

  localparam logic [ADDR_W-1:0] TOP = {ADDR_W{1'b1}};

  // micro-op: {is_write, background[1:0]}
  function automatic logic [2:0] uop(input logic [3:0] e, input logic [2:0] o);
    case (e)
      4'd0: return 3'b100;
      4'd1: return (o == 3'd0) ? 3'b000 : 3'b111;
      4'd2: case (o)
              3'd0: return 3'b011;
              3'd1: return 3'b100;
              3'd4: return 3'b111;
              default: return 3'b000;
            endcase
      4'd3: return (o == 3'd0) ? 3'b011 : 3'b100;
      4'd4: case (o)
              3'd0: return 3'b000;
              3'd1: return 3'b111;
              3'd4: return 3'b100;
              default: return 3'b011;
            endcase
      4'd5: return 3'b000;
      4'd6: case (o)
              3'd0: return 3'b000;
              3'd1: return 3'b101;
              3'd2: return 3'b110;
              default: return 3'b010;
            endcase
      4'd7: case (o)
              3'd0: return 3'b010;
              3'd1: return 3'b101;
              default: return 3'b001;
            endcase
      default: return 3'b001;
    endcase
  endfunction

  function automatic logic [2:0] last_op_of(input logic [3:0] e);
    case (e)
      4'd0, 4'd5, 4'd8: return 3'd0;
      4'd1, 4'd3:       return 3'd1;
      4'd7:             return 3'd2;
      4'd6:             return 3'd3;
      default:          return 3'd4;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] spread(input logic [1:0] p);
    logic [DATA_W-1:0] w;
    for (int i = 0; i < DATA_W; i++) w[i] = p[i % 2];
    return w;
  endfunction

  logic              busy, drain, mode;
  logic [3:0]        elem;
  logic [2:0]        op;
  logic [ADDR_W-1:0] addr;
  logic              chk_v;
  logic [DATA_W-1:0] chk_exp;
  logic [ADDR_W-1:0] chk_addr;
  logic [3:0]        chk_elem;

  wire [2:0] cur       = uop(elem, op);
  wire [3:0] nxt_elem  = elem + 4'd1;
  wire       down      = (elem == 4'd1);
  wire       last_op   = (op == last_op_of(elem));
  wire       last_addr = down ? (addr == '0) : (addr == TOP);
  wire       last_elem = (elem == (mode ? 4'd8 : 4'd5));
  wire       mismatch  = chk_v && (mem_rdata != chk_exp);
  wire       accept    = start && !busy && !drain;

  assign mem_addr  = addr;
  assign mem_wdata = spread(cur[1:0]);
  assign mem_we    = busy && cur[2];
  assign mem_re    = busy && !cur[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; drain <= 1'b0; mode <= 1'b0; done <= 1'b0;
      elem <= '0; op <= '0; addr <= '0;
      fail <= 1'b0; fail_addr <= '0; fail_elem <= '0;
      chk_v <= 1'b0; chk_exp <= '0; chk_addr <= '0; chk_elem <= '0;
    end else begin
      done     <= 1'b0;
      chk_v    <= mem_re;
      chk_exp  <= mem_wdata;
      chk_addr <= addr;
      chk_elem <= elem;
      if (mismatch && !fail) begin
        fail      <= 1'b1;
        fail_addr <= chk_addr;
        fail_elem <= chk_elem;
      end
      if (accept) begin
        busy <= 1'b1; mode <= word_mode;
        elem <= '0; op <= '0; addr <= '0;
        fail <= 1'b0;
      end else if (busy) begin
        if (mismatch && stop_on_fail) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else if (!last_op) begin
          op <= op + 3'd1;
        end else begin
          op <= '0;
          if (!last_addr) addr <= down ? addr - 1'b1 : addr + 1'b1;
          else if (last_elem) begin busy <= 1'b0; drain <= 1'b1; end
          else begin
            elem <= nxt_elem;
            addr <= (nxt_elem == 4'd1) ? TOP : '0;
          end
        end
      end else if (drain) begin
        drain <= 1'b0;
        done  <= 1'b1;
      end
    end
  end

  AST_ONE_OP: assert property (@(posedge clk) disable iff (!rst_n) !(mem_we && mem_re)); // R2
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> !mem_we && !mem_re); // R1
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R5
  AST_FAIL_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (fail && !accept) |=> fail && $stable(fail_addr) && $stable(fail_elem)); // R6
  AST_STOP_END: assert property (@(posedge clk) disable iff (!rst_n) (mismatch && !fail && stop_on_fail && busy && !accept) |=> done && fail && !busy); // R7
  AST_START_IGN: assert property (@(posedge clk) disable iff (!rst_n) (busy && start && !(mismatch && stop_on_fail) && !(last_op && last_addr && last_elem)) |=> busy); // R9

endmodule

// File: tb/march_lr_bist_test.sv
module march_lr_bist_test;
  localparam int AW = 3;
  localparam int DW = 4;
  localparam int N  = 1 << AW;

  logic clk = 0, rst_n = 0, start = 0, word_mode = 0, stop_on_fail = 0;
  logic done, fail, mem_we, mem_re;
  logic [AW-1:0] fail_addr, mem_addr;
  logic [3:0] fail_elem;
  logic [DW-1:0] mem_wdata, mem_rdata;

  always #4 clk = ~clk;

  march_lr_bist #(.ADDR_W(AW), .DATA_W(DW)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .word_mode(word_mode),
    .stop_on_fail(stop_on_fail), .done(done), .fail(fail), .fail_addr(fail_addr),
    .fail_elem(fail_elem), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_we(mem_we), .mem_re(mem_re), .mem_rdata(mem_rdata));

  logic [DW-1:0] mem [N];
  logic sa_en = 0, sa_val = 0, br_en = 0;
  logic [AW-1:0] sa_addr = 0;

  function automatic logic [DW-1:0] faulty(input logic [DW-1:0] v, input logic [AW-1:0] a);
    logic [DW-1:0] r = v;
    if (sa_en && a == sa_addr) r[0] = sa_val;
    if (br_en) begin r[0] = v[0] & v[1]; r[1] = v[0] & v[1]; end
    return r;
  endfunction

  always @(posedge clk) begin
    if (mem_we) mem[mem_addr] <= mem_wdata;
    if (mem_re) mem_rdata <= faulty(mem[mem_addr], mem_addr);
  end

  int n_checks = 0, n_fail = 0;
  int reads, writes, w01, w10, wbad, opn, cyc;
  logic [AW-1:0] a_first, a_second;

  task automatic chk(input string req, input logic ok, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (mem_we) begin
      writes++;
      if (mem_wdata == 4'b0101) w01++;
      else if (mem_wdata == 4'b1010) w10++;
      else if (mem_wdata != 4'b0000 && mem_wdata != 4'b1111) wbad++;
    end
    if (mem_re) reads++;
    if (mem_we || mem_re) begin
      if (opn == N) a_first = mem_addr;
      if (opn == N + 2) a_second = mem_addr;
      opn++;
    end
  end

  task automatic run(input logic wm, input logic sf, input int poke_at);
    reads = 0; writes = 0; w01 = 0; w10 = 0; wbad = 0; opn = 0; cyc = 0;
    word_mode = wm; stop_on_fail = sf;
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
    while (!done && cyc < 1000) begin
      @(negedge clk);
      cyc++;
      if (cyc == poke_at) start = 1; else start = 0;
    end
    start = 0;
  endtask

  initial begin
    #2000000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) mem[i] = 4'hA;
    repeat (3) @(negedge clk);
    chk("R1 reset done/fail", !done && !fail, {done, fail}, 0);
    chk("R1 reset enables", !mem_we && !mem_re, {mem_we, mem_re}, 0);
    rst_n = 1;

    // bit mode, good memory
    run(0, 0, 0);
    chk("R5 bit-mode length", cyc == 16*N + 1, cyc, 16*N + 1);
    chk("R10 pass bit mode", !fail, fail, 0);
    chk("R2 reads", reads == 9*N, reads, 9*N);
    chk("R2 writes", writes == 7*N, writes, 7*N);
    chk("R2 data solid", wbad == 0 && w01 == 0 && w10 == 0, wbad + w01 + w10, 0);
    chk("R3 first down addr", a_first == N-1, a_first, N-1);
    chk("R3 second down addr", a_second == N-2, a_second, N-2);
    begin
      int bad = 0;
      for (int i = 0; i < N; i++) if (mem[i] != 0) bad++;
      chk("R2 final zero", bad == 0, bad, 0);
    end
    @(negedge clk);
    chk("R5 done one cycle", !done, done, 0);

    // word mode, good memory
    run(1, 0, 0);
    chk("R5 word-mode length", cyc == 24*N + 1, cyc, 24*N + 1);
    chk("R10 pass word mode", !fail, fail, 0);
    chk("R4 reads", reads == 14*N, reads, 14*N);
    chk("R4 writes", writes == 10*N, writes, 10*N);
    chk("R4 bg01 writes", w01 == 2*N, w01, 2*N);
    chk("R4 bg10 writes", w10 == N, w10, N);
    begin
      int bad = 0;
      for (int i = 0; i < N; i++) if (mem[i] != 4'b0101) bad++;
      chk("R4 final 01 background", bad == 0, bad, 0);
    end

    // start pulse mid-run ignored
    run(0, 0, 37);
    chk("R9 start ignored length", cyc == 16*N + 1, cyc, 16*N + 1);

    // stuck-at-1 bit0 addr 5, continue mode
    sa_en = 1; sa_val = 1; sa_addr = 5;
    run(0, 0, 0);
    chk("R8 full length on fail", cyc == 16*N + 1, cyc, 16*N + 1);
    chk("R6 fail set", fail, fail, 1);
    chk("R6 fail addr", fail_addr == 5, fail_addr, 5);
    chk("R6 fail elem", fail_elem == 1, fail_elem, 1);

    // stuck-at-0 bit0 addr 3, stop mode
    sa_val = 0; sa_addr = 3;
    run(0, 1, 0);
    chk("R7 stop early", cyc < 16*N + 1, cyc, 16*N + 1);
    chk("R7 fail with done", fail && done, fail, 1);
    chk("R7 fail addr", fail_addr == 3, fail_addr, 3);
    chk("R7 fail elem", fail_elem == 2, fail_elem, 2);

    // new run clears fail
    sa_en = 0;
    run(0, 0, 0);
    chk("R10 fail cleared on restart", !fail, fail, 0);

    // intra-word bridge
    br_en = 1;
    run(0, 0, 0);
    chk("R11 bridge passes bit mode", !fail, fail, 0);
    run(1, 0, 0);
    chk("R11 bridge fails word mode", fail, fail, 1);
    chk("R11 bridge addr", fail_addr == 0, fail_addr, 0);
    chk("R11 bridge elem", fail_elem == 6, fail_elem, 6);
    br_en = 0;

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule